// File: doc/BRIEF.md
# Sixteen-Bit Timer and Event Counter

The block is a 16-bit up-counter behind an 8-bit synchronous register port. Software selects one of three counting sources. Timer mode counts ticks of the system clock after a power-of-two prescaler. Event mode counts transitions of an external input pin. Pulse-width mode measures one pulse on that pin: it counts prescaled ticks while the pin is at its active level and then halts by itself. When the counter passes 0xFFFF it reloads from a preload register and raises a sticky interrupt request.

The external pin is asynchronous. It passes through a two-flop synchroniser and an edge detector before it reaches the count logic, so every pin event acts on the counter a fixed number of clock edges after it occurs. Reading the low count byte captures the high byte in a holding register, so two byte reads return one coherent 16-bit value while the counter is running.

The register port has no stream traffic and no back-pressure. A read or write strobe completes in the cycle it is presented, and read data is combinational from the address.

Top module: `evt_timer16`

## Requirements
- R1: After reset every register reads 0x00 at all four addresses and `tmr_irq` is low.
- R2: Address 0 writes the low preload byte and address 1 writes the high preload byte. While the run bit is 0, such a write also loads the whole counter with the updated preload value. While the run bit is 0, the counter otherwise holds its value.
- R3: Address 2 is the control register: bits [1:0] select the mode (00 timer, 01 event, 10 pulse width, 11 acts as timer), bit 2 selects polarity, bit 3 is the run bit, and bits [7:4] hold the prescale select S. In timer mode with run set, the counter advances once every 2^S clock cycles. The first advance comes 2^S edges after the edge that sets run.
- R4: An advance from 0xFFFF loads the counter from the preload register and sets the overflow flag. `tmr_irq` equals the overflow flag.
- R5: The overflow flag is bit 0 of address 3 and stays set until a write to address 3 with bit 0 = 1. Writing 0 to that bit leaves the flag set.
- R6: In event mode the counter advances once per active pin edge: rising when polarity is 0, falling when polarity is 1. The opposite edge and the time the pin spends at a level have no effect.
- R7: A pin change made between clock edges k-1 and k changes the counter at edge k+2. Before that edge the count reads unchanged.
- R8: In pulse-width mode the active edge starts the measurement and the opposite edge ends it. The counter advances on each prescaled tick from the edge after the start edge is detected up to, but not including, the edge where the end edge is detected. At that edge the run bit clears. With S = 0 and the pin at its active level for N cycles, the count grows by N-1.
- R9: After a pulse-width measurement ends, further pin pulses leave the count unchanged until software sets run again.
- R10: A read of address 0 returns the live low byte and captures the high byte. A read of address 1 returns the captured byte.
- R11: A read of address 2 returns the control register as written, with the run bit showing its current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_rd | input | 1 | Read strobe; a read of address 0 captures the high byte |
| bus_addr | input | 2 | Register address: 0 count/preload low, 1 count/preload high, 2 control, 3 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| tmr_pin | input | 1 | Asynchronous external event or pulse input |
| tmr_irq | output | 1 | Sticky overflow interrupt request |

## Verification
The bench drives the counter across 0xFFFF in timer mode. A design that wrapped to zero instead of reloading, or that let a zero write clear the flag, would read back the wrong count or status. It reads the count one edge before and at the edge where a pin edge should land, which exposes a synchroniser that is one stage too short or too long. It measures an active-high and an active-low pulse, then sends more pulses. A design that counted on the start or end edge would be off by one, and a design without the single-shot stop would keep counting. A low-then-high read taken as the high byte rolls over shows whether the high byte was captured or read live.

// File: rtl/evt_timer16_pkg.sv
package evt_timer16_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_PULSE = 2'b10,
    MODE_SPARE = 2'b11
  } mode_e;

  localparam int          AW       = 2;
  localparam logic [AW-1:0] ADDR_LO   = 2'd0;
  localparam logic [AW-1:0] ADDR_HI   = 2'd1;
  localparam logic [AW-1:0] ADDR_CTRL = 2'd2;
  localparam logic [AW-1:0] ADDR_STAT = 2'd3;

  localparam int CTRL_POL = 2;
  localparam int CTRL_RUN = 3;
  localparam int CTRL_SEL = 4;
endpackage

// File: rtl/evt_timer16_prescale.sv
module evt_timer16_prescale #(
  parameter int STAGES = 16,
  localparam int SEL_W = $clog2(STAGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [STAGES-1:0] div_q;
  logic [STAGES-1:0] mask;

  // mask has the low sel bits set; a tick comes when those bits are all ones
  for (genvar i = 0; i < STAGES; i++) begin : g_mask
    assign mask[i] = (int'(sel) > i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) div_q <= '0;
    else                div_q <= div_q + 1'b1;
  end

  assign tick = run && ((div_q & mask) == mask);

  // R3: with a divide ratio above one, ticks never come back to back
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != '0) |=> (!tick || sel == '0));

  // R3: the edge that starts the prescaler is never itself a tick for S > 0
  p_first_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(run) && sel != '0) |-> !tick);
endmodule

// File: rtl/evt_timer16_insync.sv
module evt_timer16_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain;
  logic            prev_q;

  assign chain[0] = pin_i;

  for (genvar i = 0; i < STAGES; i++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n) chain[i+1] <= 1'b0;
      else        chain[i+1] <= chain[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain[STAGES];
  end

  assign rise = chain[STAGES] & ~prev_q;
  assign fall = ~chain[STAGES] & prev_q;

  // R7: a detected rising edge is the pin seen high STAGES edges back
  p_rise_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> $past(pin_i, STAGES));

  // R7: a detected falling edge is the pin seen low STAGES edges back
  p_fall_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> !$past(pin_i, STAGES));
endmodule

// File: rtl/evt_timer16_core.sv
module evt_timer16_core
  import evt_timer16_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  mode_e         mode,
  input  logic          pol,
  input  logic          run,
  input  logic          tick,
  input  logic          ev_rise,
  input  logic          ev_fall,
  input  logic          load_en,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] reload_val,
  input  logic          ovf_clr,
  output logic [CW-1:0] count,
  output logic          ovf,
  output logic          run_done
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic act_edge, end_edge;
  logic meas_q, meas_nxt;
  logic inc;
  logic at_max;

  assign act_edge = pol ? ev_fall : ev_rise;
  assign end_edge = pol ? ev_rise : ev_fall;
  assign at_max   = (count == CNT_MAX);

  always_comb begin
    unique case (mode)
      MODE_EVENT: inc = run && act_edge;
      MODE_PULSE: inc = run && meas_q && tick && !end_edge;
      default:    inc = run && tick;
    endcase
  end

  always_comb begin
    if (!run || mode != MODE_PULSE) meas_nxt = 1'b0;
    else if (!meas_q)               meas_nxt = act_edge;
    else                            meas_nxt = !end_edge;
  end

  assign run_done = run && (mode == MODE_PULSE) && meas_q && end_edge;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      ovf    <= 1'b0;
      meas_q <= 1'b0;
    end else begin
      if (load_en)  count <= load_val;
      else if (inc) count <= at_max ? reload_val : count + 1'b1;
      if (inc && at_max) ovf <= 1'b1;
      else if (ovf_clr)  ovf <= 1'b0;
      meas_q <= meas_nxt;
    end
  end

  // R5: the flag holds until a clear request arrives
  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);

  // R2: a stopped counter changes only through a load
  p_stopped_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load_en) |=> $stable(count));

  // R3: an ordinary advance adds exactly one
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load_en && !at_max) |=> (count == $past(count) + 1'b1));

  // R4: an advance from the top value reloads and raises the flag
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load_en && at_max) |=> (count == $past(reload_val) && ovf));

  // R9: no measurement is under way once run is low
  p_single_shot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !meas_q);
endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
  import evt_timer16_pkg::*;
#(
  parameter int DW              = 8,
  parameter int PRESCALE_STAGES = 16,
  parameter int SYNC_STAGES     = 2,
  localparam int CW             = 2 * DW,
  localparam int SEL_W          = $clog2(PRESCALE_STAGES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          tmr_pin,
  output logic          tmr_irq
);
  logic [DW-1:0] ctrl_q;
  logic [CW-1:0] preload_q, preload_nxt;
  logic [DW-1:0] hi_snap_q;
  logic [CW-1:0] count;
  logic          ovf;
  logic          run_done;
  logic          tick, ev_rise, ev_fall;
  logic          wr_lo, wr_hi, wr_ctrl, wr_stat;
  logic          load_en, ovf_clr;
  logic          run_bit;
  mode_e         mode;

  assign wr_lo   = bus_wr && bus_addr == ADDR_LO;
  assign wr_hi   = bus_wr && bus_addr == ADDR_HI;
  assign wr_ctrl = bus_wr && bus_addr == ADDR_CTRL;
  assign wr_stat = bus_wr && bus_addr == ADDR_STAT;

  assign run_bit = ctrl_q[CTRL_RUN];
  assign mode    = mode_e'(ctrl_q[1:0]);

  always_comb begin
    preload_nxt = preload_q;
    if (wr_lo) preload_nxt[DW-1:0]  = bus_wdata;
    if (wr_hi) preload_nxt[CW-1:DW] = bus_wdata;
  end

  assign load_en = (wr_lo || wr_hi) && !run_bit;
  assign ovf_clr = wr_stat && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      preload_q <= '0;
      hi_snap_q <= '0;
    end else begin
      preload_q <= preload_nxt;
      if (wr_ctrl)       ctrl_q <= bus_wdata;
      else if (run_done) ctrl_q[CTRL_RUN] <= 1'b0;
      if (bus_rd && bus_addr == ADDR_LO) hi_snap_q <= count[CW-1:DW];
    end
  end

  always_comb begin
    unique case (bus_addr)
      ADDR_LO:   bus_rdata = count[DW-1:0];
      ADDR_HI:   bus_rdata = hi_snap_q;
      ADDR_CTRL: bus_rdata = ctrl_q;
      default:   bus_rdata = {{(DW-1){1'b0}}, ovf};
    endcase
  end

  assign tmr_irq = ovf;

  evt_timer16_prescale #(.STAGES(PRESCALE_STAGES)) u_prescale (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_bit),
    .sel   (ctrl_q[CTRL_SEL +: SEL_W]),
    .tick  (tick)
  );

  evt_timer16_insync #(.STAGES(SYNC_STAGES)) u_insync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (tmr_pin),
    .rise  (ev_rise),
    .fall  (ev_fall)
  );

  evt_timer16_core #(.CW(CW)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .pol        (ctrl_q[CTRL_POL]),
    .run        (run_bit),
    .tick       (tick),
    .ev_rise    (ev_rise),
    .ev_fall    (ev_fall),
    .load_en    (load_en),
    .load_val   (preload_nxt),
    .reload_val (preload_q),
    .ovf_clr    (ovf_clr),
    .count      (count),
    .ovf        (ovf),
    .run_done   (run_done)
  );

  // R8: the end of a measurement drops the run bit unless software rewrites it
  p_run_selfclear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_done && !wr_ctrl) |=> !ctrl_q[CTRL_RUN]);

  // R10: a high read right after a low read returns the byte captured by it
  p_snapshot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_HI && $past(bus_rd && bus_addr == ADDR_LO))
      |-> (bus_rdata == $past(count[CW-1:DW])));

  // R4: the request pin follows the status bit
  p_irq_matches_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_STAT) |-> (bus_rdata[0] == tmr_irq));
endmodule

// File: tb/evt_timer16_bench.sv
module evt_timer16_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       tmr_pin = 1'b0;
  logic       tmr_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  evt_timer16 u_evt_timer16 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tmr_pin   (tmr_pin),
    .tmr_irq   (tmr_irq)
  );

  // monitor: pops the expected read data and compares at mid-cycle
  always @(negedge clk) begin
    if (bus_rd) begin
      n_chk++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected read: actual %02h expected none", bus_rdata);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        if (bus_rdata !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %02h expected %02h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  // driver: pushes the expected value, then issues the read
  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    sb_q.push_back('{exp, tag});
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk);
    n_chk++;
    if (tmr_irq !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, tmr_irq, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic pin_to(input logic v);
    @(posedge clk); #1;
    tmr_pin = v;
  endtask

  initial begin
    idle(3);
    #1 rst_n = 1'b1;

    // R1: reset state
    rd(2'd0, 8'h00, "R1 low after reset");
    rd(2'd1, 8'h00, "R1 high after reset");
    rd(2'd2, 8'h00, "R1 control after reset");
    rd(2'd3, 8'h00, "R1 status after reset");
    chk_irq(1'b0, "R1 irq after reset");

    // R11: control readback, run clear
    wr(2'd2, 8'hF4);
    rd(2'd2, 8'hF4, "R11 control readback");

    // R2: stopped preload write loads counter
    wr(2'd0, 8'h34);
    wr(2'd1, 8'h12);
    idle(3);
    rd(2'd0, 8'h34, "R2 loaded low");
    rd(2'd1, 8'h12, "R2 loaded high");

    // R3: timer mode S=0, 2+3 advances from 0x0100
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h01);
    wr(2'd2, 8'h08);
    idle(3);
    wr(2'd2, 8'h00);
    rd(2'd0, 8'h05, "R3 timer S=0 low");
    rd(2'd1, 8'h01, "R3 timer S=0 high");

    // R3: S=2, stop 12 edges after start: 3 advances
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h28);
    idle(10);
    wr(2'd2, 8'h20);
    rd(2'd0, 8'h03, "R3 timer S=2 advances");

    // R4: overflow from 0xFFFF reloads 0xFFFA and sets flag
    wr(2'd0, 8'hFA);
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'h08);
    idle(4);
    wr(2'd2, 8'h00);
    rd(2'd0, 8'hFA, "R4 reload low");
    rd(2'd1, 8'hFF, "R4 reload high");
    rd(2'd3, 8'h01, "R4 flag set");
    chk_irq(1'b1, "R4 irq raised");

    // R5: zero write keeps flag, one write clears
    wr(2'd3, 8'h00);
    rd(2'd3, 8'h01, "R5 flag kept on zero write");
    wr(2'd3, 8'h01);
    rd(2'd3, 8'h00, "R5 flag cleared");
    chk_irq(1'b0, "R5 irq cleared");

    // R10: coherent read across 0x00FF -> 0x0100
    wr(2'd0, 8'hFE);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h08);
    rd(2'd0, 8'hFF, "R10 live low");
    rd(2'd1, 8'h00, "R10 captured high");
    wr(2'd2, 8'h00);

    // R6: event mode, rising edges, levels held long
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h09);
    for (int i = 0; i < 3; i++) begin
      pin_to(1'b1); idle(6);
      pin_to(1'b0); idle(6);
    end
    rd(2'd0, 8'h03, "R6 rising edges counted");

    // R7: pin edge lands at the third edge
    pin_to(1'b1);
    rd(2'd0, 8'h03, "R7 count before sync latency");
    rd(2'd0, 8'h04, "R7 count after sync latency");
    pin_to(1'b0); idle(6);
    wr(2'd2, 8'h01);

    // R6: falling polarity ignores rising edges
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h0D);
    pin_to(1'b1); idle(6);
    rd(2'd0, 8'h00, "R6 rising edge ignored in falling polarity");
    pin_to(1'b0); idle(6);
    pin_to(1'b1); idle(6);
    pin_to(1'b0); idle(6);
    rd(2'd0, 8'h02, "R6 falling edges counted");
    wr(2'd2, 8'h00);

    // R8: active-high pulse of 20 cycles -> 19
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h0A);
    idle(3);
    pin_to(1'b1);
    idle(20);
    #1 tmr_pin = 1'b0;
    idle(6);
    rd(2'd2, 8'h02, "R8 run cleared after pulse");
    rd(2'd0, 8'h13, "R8 active-high width");

    // R9: later pulses ignored
    pin_to(1'b1); idle(10);
    pin_to(1'b0); idle(6);
    rd(2'd0, 8'h13, "R9 count held after single shot");

    // R8: active-low pulse of 10 cycles -> 9
    pin_to(1'b1); idle(6);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h0E);
    idle(3);
    pin_to(1'b0);
    idle(10);
    #1 tmr_pin = 1'b1;
    idle(6);
    rd(2'd2, 8'h06, "R8 run cleared after low pulse");
    rd(2'd0, 8'h09, "R8 active-low width");

    idle(4);
    if (sb_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule